// File: doc/BRIEF.md
# Load/Store Ordering and Forwarding Unit

This block holds the memory operations of an out-of-order core between dispatch and retirement. Loads and stores each take a slot in their own circular queue in program order at dispatch. Their doubleword address, byte enables and store data arrive later, when address generation finishes. Every waiting load is compared against all stores that are older than it in program order. From that comparison the block decides whether the load takes its bytes from a store, reads the data cache, or keeps waiting.

A load that the dependence predictor has tagged as speculative may read the cache even while older store addresses are unknown. If one of those stores later resolves to bytes that the load covers, the block raises a flush that names the load's sequence number. The core then squashes that load and everything younger. Stores go to the cache only after retirement, one at a time, oldest first. The cache port carries one request at a time, and a request that gets a negative acknowledgement is sent again.

Top module: `lsq_disambig`

## Requirements
- R1: After reset both queues are empty: `lq_full` and `sq_full` are 0, `ld_alloc_idx` and `st_alloc_idx` are 0, and `dc_req_valid`, `ld_wb_valid` and `flush_valid` are 0.
- R2: Entries are taken in program order at the index shown on `ld_alloc_idx`/`st_alloc_idx`, which advances by one and wraps. The full flag is 1 exactly when 8 entries are held. A store allocated in the same cycle as a load counts as older than that load.
- R3: A store matches a load when both carry the same doubleword address (address bits [63:3]) and their byte enables share at least one bit. A load whose enabled bytes all lie inside the chosen matching store's enables completes with `ld_wb_fwd`=1, without a cache read. Its data carries the store's bytes in the load's byte lanes and zero in the other lanes.
- R4: When several older resolved stores match, data comes from the youngest of them. Stores allocated after the load never supply its data.
- R5: When all older stores are resolved and none matches, the load reads the cache. It completes with `ld_wb_fwd`=0 and with the returned doubleword masked to its byte enables.
- R6: A load not tagged speculative makes no cache request and does not complete while any older store address is unresolved.
- R7: A speculative load may read the cache past unresolved older stores. If an older store then resolves to a match with a load that has already been sent or completed, `flush_valid` pulses in the cycle after that store's address write, with `flush_seq` holding the load's sequence number (the oldest such load when several match). A store that resolves without a match raises no flush.
- R8: A load held back by unresolved older stores completes by forwarding once the matching store resolves and covers its bytes.
- R9: A load whose bytes are only partly covered by the chosen matching store waits until that store has been written to the cache, and then reads the cache.
- R10: Stores are written to the cache (`dc_req_write`=1) only after `st_retire`, in allocation order, each with its own doubleword address, byte enables and data.
- R11: A response with `dc_resp_nack`=1 causes the same request to be issued again, and a nacked read produces no load completion.
- R12: At most one cache request is outstanding: `dc_req_valid` is a one-cycle pulse, and no new pulse appears until the previous request has received a response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_alloc_valid | input | 1 | Reserve a load slot |
| ld_alloc_spec | input | 1 | Load is tagged speculative by the predictor |
| ld_alloc_seq | input | SEQ_W | Sequence number of the load |
| ld_alloc_idx | output | log2(LQ_N) | Slot the next load takes |
| lq_full | output | 1 | Load queue holds LQ_N entries |
| st_alloc_valid | input | 1 | Reserve a store slot |
| st_alloc_idx | output | log2(SQ_N) | Slot the next store takes |
| sq_full | output | 1 | Store queue holds SQ_N entries |
| ld_agu_valid | input | 1 | Load address write |
| ld_agu_idx | input | log2(LQ_N) | Load slot being written |
| ld_agu_dw | input | 61 | Load doubleword address (bits 63:3) |
| ld_agu_be | input | 8 | Load byte enables |
| st_agu_valid | input | 1 | Store address and data write |
| st_agu_idx | input | log2(SQ_N) | Store slot being written |
| st_agu_dw | input | 61 | Store doubleword address |
| st_agu_be | input | 8 | Store byte enables |
| st_agu_data | input | 64 | Store data in byte lanes |
| ld_retire | input | 1 | Free the oldest load |
| st_retire | input | 1 | Mark the next store as retired |
| dc_req_valid | output | 1 | Cache request pulse |
| dc_req_write | output | 1 | Request is a store write |
| dc_req_addr | output | 64 | Doubleword-aligned address |
| dc_req_be | output | 8 | Byte enables |
| dc_req_wdata | output | 64 | Write data |
| dc_resp_valid | input | 1 | Cache response |
| dc_resp_nack | input | 1 | Request refused, must be retried |
| dc_resp_rdata | input | 64 | Read doubleword |
| ld_wb_valid | output | 1 | Load completion |
| ld_wb_idx | output | log2(LQ_N) | Completing load slot |
| ld_wb_data | output | 64 | Load data, zero outside its byte enables |
| ld_wb_fwd | output | 1 | Data came from a store |
| flush_valid | output | 1 | Ordering violation pulse |
| flush_seq | output | SEQ_W | Sequence number of the violating load |

## Verification
The bench aims at younger stores at a load's address that must be ignored, at several older stores matching at once, and at byte masks that overlap only in part. Getting any of these wrong shows up as the wrong forwarded bytes or as a forward that should have been a wait. It holds a non-speculative load behind an unresolved store: a design that lets the load through sends an early cache read and returns stale data. It lets a speculative load run ahead, then resolves the store to both an overlapping and a non-overlapping address. A missed flush or a spurious flush shows directly, as does a wrong sequence number. Nacked requests and the retirement order of stores are checked against a behavioural cache. A lost retry hangs the load, and an early or reordered store write corrupts the memory image that later loads read back.

// File: rtl/lsq_pkg.sv
// Shared types for the load/store ordering unit.
// Assumes 64-bit addresses and data, matched at doubleword granularity.
package lsq_pkg;
    localparam int ADDR_W = 64;
    localparam int DATA_W = 64;
    localparam int BYTES  = DATA_W / 8;
    localparam int DW_LSB = $clog2(BYTES);

    typedef logic [ADDR_W-1:DW_LSB] dw_addr_t;
    typedef logic [BYTES-1:0]       be_t;

    // One store queue slot
    typedef struct packed {
        logic                valid;
        logic                addr_ok;
        logic                retired;
        dw_addr_t            dw;
        be_t                 be;
        logic [DATA_W-1:0]   data;
    } st_ent_t;

    // Per-load decision each cycle
    typedef enum logic [1:0] {
        LD_HOLD  = 2'd0,
        LD_FWD   = 2'd1,
        LD_CACHE = 2'd2
    } ld_verdict_e;

    // Widen byte enables into a bit mask
    function automatic logic [DATA_W-1:0] be_expand(input be_t be);
        logic [DATA_W-1:0] m;
        for (int b = 0; b < BYTES; b++) begin
            m[b*8 +: 8] = {8{be[b]}};
        end
        return m;
    endfunction
endpackage

// File: rtl/lsq_age_pick.sv
// Picks the oldest or youngest requester in a circular queue.
// Assumes N is a power of two; age order starts at head.
module lsq_age_pick #(
    parameter int N           = 8,
    parameter bit PICK_OLDEST = 1'b1,
    localparam int IW         = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] head,
    output logic          hit,
    output logic [IW-1:0] idx
);
    // Walk from head; keep first hit (oldest) or last hit (youngest)
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int k = 0; k < N; k++) begin
            logic [IW-1:0] pos;
            pos = head + IW'(k);
            if (req[pos] && (!PICK_OLDEST || !hit)) begin
                hit = 1'b1;
                idx = pos;
            end
        end
    end
endmodule

// File: rtl/lsq_cam.sv
// Associative compare of one load against every store slot.
// A hit needs a valid, resolved store with the same doubleword and shared bytes.
module lsq_cam
    import lsq_pkg::*;
#(
    parameter int N = 8
) (
    input  dw_addr_t  ld_dw,
    input  be_t       ld_be,
    input  st_ent_t   ents [N],
    output logic [N-1:0] hit
);
    generate
        for (genvar g = 0; g < N; g++) begin : g_row
            assign hit[g] = ents[g].valid && ents[g].addr_ok &&
                            (ents[g].dw == ld_dw) && (|(ents[g].be & ld_be));
        end
    endgenerate
endmodule

// File: rtl/lsq_store_q.sv
// Circular store queue: allocate at tail, fill at address generation,
// mark retired in order, release at head once the cache accepts the write.
// Assumes the caller never allocates when full and retires only held stores.
module lsq_store_q
    import lsq_pkg::*;
#(
    parameter int N   = 8,
    localparam int IW = $clog2(N),
    localparam int CW = $clog2(N + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc,
    input  logic              agu_valid,
    input  logic [IW-1:0]     agu_idx,
    input  dw_addr_t          agu_dw,
    input  be_t               agu_be,
    input  logic [DATA_W-1:0] agu_data,
    input  logic              retire,
    input  logic              pop,
    output st_ent_t           ents [N],
    output logic [IW-1:0]     head,
    output logic [IW-1:0]     tail,
    output logic              full,
    output logic              drain_ok
);
    logic [IW-1:0] cmt;
    logic [CW-1:0] cnt;

    assign full     = (cnt == CW'(N));
    assign drain_ok = ents[head].valid && ents[head].retired && ents[head].addr_ok;

    // Slot state and pointers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) ents[i] <= '0;
            head <= '0;
            tail <= '0;
            cmt  <= '0;
            cnt  <= '0;
        end else begin
            if (alloc) begin
                ents[tail]       <= '0;
                ents[tail].valid <= 1'b1;
                tail             <= tail + 1'b1;
            end
            if (agu_valid) begin
                ents[agu_idx].addr_ok <= 1'b1;
                ents[agu_idx].dw      <= agu_dw;
                ents[agu_idx].be      <= agu_be;
                ents[agu_idx].data    <= agu_data;
            end
            if (retire) begin
                ents[cmt].retired <= 1'b1;
                cmt               <= cmt + 1'b1;
            end
            if (pop) begin
                ents[head].valid <= 1'b0;
                head             <= head + 1'b1;
            end
            cnt <= cnt + CW'(alloc) - CW'(pop);
        end
    end
endmodule

// File: rtl/lsq_disambig.sv
// Load/store ordering unit top. Keeps the load queue, compares loads
// against older stores, chooses forward/cache/hold, drives the single
// outstanding cache request, and flags speculative-load violations.
// Assumes LQ_N and SQ_N are powers of two and a cache response follows every request.
module lsq_disambig
    import lsq_pkg::*;
#(
    parameter int LQ_N  = 8,
    parameter int SQ_N  = 8,
    parameter int SEQ_W = 8,
    localparam int LIW  = $clog2(LQ_N),
    localparam int SIW  = $clog2(SQ_N),
    localparam int LCW  = $clog2(LQ_N + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_alloc_valid,
    input  logic              ld_alloc_spec,
    input  logic [SEQ_W-1:0]  ld_alloc_seq,
    output logic [LIW-1:0]    ld_alloc_idx,
    output logic              lq_full,
    input  logic              st_alloc_valid,
    output logic [SIW-1:0]    st_alloc_idx,
    output logic              sq_full,
    input  logic              ld_agu_valid,
    input  logic [LIW-1:0]    ld_agu_idx,
    input  logic [60:0]       ld_agu_dw,
    input  logic [7:0]        ld_agu_be,
    input  logic              st_agu_valid,
    input  logic [SIW-1:0]    st_agu_idx,
    input  logic [60:0]       st_agu_dw,
    input  logic [7:0]        st_agu_be,
    input  logic [63:0]       st_agu_data,
    input  logic              ld_retire,
    input  logic              st_retire,
    output logic              dc_req_valid,
    output logic              dc_req_write,
    output logic [63:0]       dc_req_addr,
    output logic [7:0]        dc_req_be,
    output logic [63:0]       dc_req_wdata,
    input  logic              dc_resp_valid,
    input  logic              dc_resp_nack,
    input  logic [63:0]       dc_resp_rdata,
    output logic              ld_wb_valid,
    output logic [LIW-1:0]    ld_wb_idx,
    output logic [63:0]       ld_wb_data,
    output logic              ld_wb_fwd,
    output logic              flush_valid,
    output logic [SEQ_W-1:0]  flush_seq
);
    // Load queue state
    logic [LQ_N-1:0] lq_v, lq_spec, lq_aok, lq_inf, lq_done;
    dw_addr_t        lq_dw    [LQ_N];
    be_t             lq_be    [LQ_N];
    logic [SEQ_W-1:0] lq_seq  [LQ_N];
    logic [SQ_N-1:0] lq_older [LQ_N];
    logic [LIW-1:0]  lq_head, lq_tail;
    logic [LCW-1:0]  lq_cnt;

    // Cache port tracking
    logic           busy, req_st;
    logic [LIW-1:0] req_idx;

    // Store queue view
    st_ent_t        st_ents [SQ_N];
    logic [SIW-1:0] sq_head, sq_tail;
    logic           st_drain_ok, st_pop, st_alloc_ok;
    logic [SQ_N-1:0] st_valid_vec, st_aok_vec, new_older;

    logic ld_alloc_ok, ld_retire_ok;

    // Per-load decision outputs
    logic [LQ_N-1:0] want_fwd, want_rd, viol;
    logic [SIW-1:0]  fwd_src [LQ_N];
    logic            fwd_hit, rd_hit, viol_hit;
    logic [LIW-1:0]  fwd_idx, rd_idx, viol_idx;

    assign lq_full      = (lq_cnt == LCW'(LQ_N));
    assign ld_alloc_idx = lq_tail;
    assign st_alloc_idx = sq_tail;
    assign ld_alloc_ok  = ld_alloc_valid && !lq_full;
    assign ld_retire_ok = ld_retire && (lq_cnt != '0);
    assign st_alloc_ok  = st_alloc_valid && !sq_full;
    assign st_pop       = busy && req_st && dc_resp_valid && !dc_resp_nack;

    lsq_store_q #(.N(SQ_N)) u_sq (
        .clk      (clk),
        .rst_n    (rst_n),
        .alloc    (st_alloc_ok),
        .agu_valid(st_agu_valid),
        .agu_idx  (st_agu_idx),
        .agu_dw   (st_agu_dw),
        .agu_be   (st_agu_be),
        .agu_data (st_agu_data),
        .retire   (st_retire),
        .pop      (st_pop),
        .ents     (st_ents),
        .head     (sq_head),
        .tail     (sq_tail),
        .full     (sq_full),
        .drain_ok (st_drain_ok)
    );

    generate
        for (genvar s = 0; s < SQ_N; s++) begin : g_stvec
            assign st_valid_vec[s] = st_ents[s].valid;
            assign st_aok_vec[s]   = st_ents[s].addr_ok;
        end
    endgenerate

    // Older-store set captured by a newly allocated load
    always_comb begin
        new_older = st_valid_vec;
        if (st_pop)      new_older[sq_head] = 1'b0;
        if (st_alloc_ok) new_older[sq_tail] = 1'b1;
    end

    generate
        for (genvar i = 0; i < LQ_N; i++) begin : g_ld
            logic [SQ_N-1:0] cam_hit, m_older, unres;
            logic            y_hit, covered, eligible;
            logic [SIW-1:0]  y_idx;
            ld_verdict_e     verdict;

            lsq_cam #(.N(SQ_N)) u_cam (
                .ld_dw(lq_dw[i]),
                .ld_be(lq_be[i]),
                .ents (st_ents),
                .hit  (cam_hit)
            );

            assign m_older = cam_hit & lq_older[i];
            assign unres   = lq_older[i] & ~st_aok_vec;

            lsq_age_pick #(.N(SQ_N), .PICK_OLDEST(1'b0)) u_young (
                .req (m_older),
                .head(sq_head),
                .hit (y_hit),
                .idx (y_idx)
            );

            assign fwd_src[i] = y_idx;
            assign covered    = ((lq_be[i] & ~st_ents[y_idx].be) == '0);
            assign eligible   = lq_v[i] && lq_aok[i] && !lq_inf[i] && !lq_done[i];

            // Forward, read the cache, or hold
            always_comb begin
                if (!lq_spec[i] && (unres != '0)) verdict = LD_HOLD;
                else if (y_hit)                   verdict = covered ? LD_FWD : LD_HOLD;
                else                              verdict = LD_CACHE;
            end

            assign want_fwd[i] = eligible && (verdict == LD_FWD);
            assign want_rd[i]  = eligible && (verdict == LD_CACHE);

            // Store resolving onto a load that already went ahead
            assign viol[i] = st_agu_valid && lq_v[i] && lq_aok[i] &&
                             (lq_inf[i] || lq_done[i]) && lq_older[i][st_agu_idx] &&
                             (lq_dw[i] == st_agu_dw) && (|(lq_be[i] & st_agu_be));
        end
    endgenerate

    lsq_age_pick #(.N(LQ_N), .PICK_OLDEST(1'b1)) u_pick_fwd (
        .req(want_fwd), .head(lq_head), .hit(fwd_hit), .idx(fwd_idx));
    lsq_age_pick #(.N(LQ_N), .PICK_OLDEST(1'b1)) u_pick_rd (
        .req(want_rd), .head(lq_head), .hit(rd_hit), .idx(rd_idx));
    lsq_age_pick #(.N(LQ_N), .PICK_OLDEST(1'b1)) u_pick_viol (
        .req(viol), .head(lq_head), .hit(viol_hit), .idx(viol_idx));

    // Load queue, cache port and completion/flush outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lq_v <= '0; lq_spec <= '0; lq_aok <= '0; lq_inf <= '0; lq_done <= '0;
            for (int i = 0; i < LQ_N; i++) begin
                lq_dw[i] <= '0; lq_be[i] <= '0; lq_seq[i] <= '0; lq_older[i] <= '0;
            end
            lq_head <= '0; lq_tail <= '0; lq_cnt <= '0;
            busy <= 1'b0; req_st <= 1'b0; req_idx <= '0;
            dc_req_valid <= 1'b0; dc_req_write <= 1'b0; dc_req_addr <= '0;
            dc_req_be <= '0; dc_req_wdata <= '0;
            ld_wb_valid <= 1'b0; ld_wb_idx <= '0; ld_wb_data <= '0; ld_wb_fwd <= 1'b0;
            flush_valid <= 1'b0; flush_seq <= '0;
        end else begin
            dc_req_valid <= 1'b0;
            ld_wb_valid  <= 1'b0;
            flush_valid  <= 1'b0;

            if (st_pop) begin
                for (int i = 0; i < LQ_N; i++) lq_older[i][sq_head] <= 1'b0;
            end
            if (ld_alloc_ok) begin
                lq_v[lq_tail]     <= 1'b1;
                lq_spec[lq_tail]  <= ld_alloc_spec;
                lq_aok[lq_tail]   <= 1'b0;
                lq_inf[lq_tail]   <= 1'b0;
                lq_done[lq_tail]  <= 1'b0;
                lq_seq[lq_tail]   <= ld_alloc_seq;
                lq_older[lq_tail] <= new_older;
                lq_tail           <= lq_tail + 1'b1;
            end
            if (ld_agu_valid) begin
                lq_aok[ld_agu_idx] <= 1'b1;
                lq_dw[ld_agu_idx]  <= ld_agu_dw;
                lq_be[ld_agu_idx]  <= ld_agu_be;
            end
            if (ld_retire_ok) begin
                lq_v[lq_head] <= 1'b0;
                lq_head       <= lq_head + 1'b1;
            end
            lq_cnt <= lq_cnt + LCW'(ld_alloc_ok) - LCW'(ld_retire_ok);

            if (busy && dc_resp_valid) begin
                busy <= 1'b0;
                if (!req_st) begin
                    lq_inf[req_idx] <= 1'b0;
                    if (!dc_resp_nack) begin
                        lq_done[req_idx] <= 1'b1;
                        ld_wb_valid      <= 1'b1;
                        ld_wb_idx        <= req_idx;
                        ld_wb_data       <= dc_resp_rdata & be_expand(lq_be[req_idx]);
                        ld_wb_fwd        <= 1'b0;
                    end
                end
            end else if (fwd_hit) begin
                lq_done[fwd_idx] <= 1'b1;
                ld_wb_valid      <= 1'b1;
                ld_wb_idx        <= fwd_idx;
                ld_wb_data       <= st_ents[fwd_src[fwd_idx]].data & be_expand(lq_be[fwd_idx]);
                ld_wb_fwd        <= 1'b1;
            end

            if (!busy) begin
                if (st_drain_ok) begin
                    busy         <= 1'b1;
                    req_st       <= 1'b1;
                    dc_req_valid <= 1'b1;
                    dc_req_write <= 1'b1;
                    dc_req_addr  <= {st_ents[sq_head].dw, {DW_LSB{1'b0}}};
                    dc_req_be    <= st_ents[sq_head].be;
                    dc_req_wdata <= st_ents[sq_head].data;
                end else if (rd_hit) begin
                    busy            <= 1'b1;
                    req_st          <= 1'b0;
                    req_idx         <= rd_idx;
                    lq_inf[rd_idx]  <= 1'b1;
                    dc_req_valid    <= 1'b1;
                    dc_req_write    <= 1'b0;
                    dc_req_addr     <= {lq_dw[rd_idx], {DW_LSB{1'b0}}};
                    dc_req_be       <= lq_be[rd_idx];
                    dc_req_wdata    <= '0;
                end
            end

            if (viol_hit) begin
                flush_valid <= 1'b1;
                flush_seq   <= lq_seq[viol_idx];
            end
        end
    end
endmodule

// File: rtl/lsq_checker.sv
// Port-level protocol checks for the ordering unit, attached by bind.
// Assumes one response per request on the cache port.
module lsq_checker (
    input logic clk,
    input logic rst_n,
    input logic st_retire,
    input logic st_agu_valid,
    input logic dc_req_valid,
    input logic dc_req_write,
    input logic dc_resp_valid,
    input logic dc_resp_nack,
    input logic ld_wb_valid,
    input logic ld_wb_fwd,
    input logic flush_valid
);
    logic       outst, last_wr;
    logic [4:0] pend_st;

    // Track outstanding request and retired-but-unwritten stores
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outst   <= 1'b0;
            last_wr <= 1'b0;
            pend_st <= '0;
        end else begin
            if (dc_req_valid) begin
                outst   <= 1'b1;
                last_wr <= dc_req_write;
            end else if (dc_resp_valid) begin
                outst <= 1'b0;
            end
            pend_st <= pend_st + 5'(st_retire)
                     - 5'(dc_resp_valid && !dc_resp_nack && last_wr && outst);
        end
    end

    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        dc_req_valid |=> !dc_req_valid); // R12
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        dc_req_valid |-> !outst); // R12
    AST_WRITE_NEEDS_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (dc_req_valid && dc_req_write) |-> (pend_st != '0)); // R10
    AST_CACHE_WB_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_wb_valid && !ld_wb_fwd) |-> $past(dc_resp_valid && !dc_resp_nack)); // R11
    AST_FLUSH_AFTER_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> $past(st_agu_valid)); // R7
endmodule

bind lsq_disambig lsq_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .st_retire    (st_retire),
    .st_agu_valid (st_agu_valid),
    .dc_req_valid (dc_req_valid),
    .dc_req_write (dc_req_write),
    .dc_resp_valid(dc_resp_valid),
    .dc_resp_nack (dc_resp_nack),
    .ld_wb_valid  (ld_wb_valid),
    .ld_wb_fwd    (ld_wb_fwd),
    .flush_valid  (flush_valid)
);

// File: tb/sim_lsq_disambig.sv
`timescale 1ns/1ps
// Directed bench with a behavioural cache and memory image, a per-clock
// monitor checking every completion and store write against expectations.
module sim_lsq_disambig;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic ld_alloc_valid = 0, ld_alloc_spec = 0;
    logic [7:0] ld_alloc_seq = 0;
    logic [2:0] ld_alloc_idx, st_alloc_idx;
    logic lq_full, sq_full;
    logic st_alloc_valid = 0;
    logic ld_agu_valid = 0; logic [2:0] ld_agu_idx = 0; logic [60:0] ld_agu_dw = 0; logic [7:0] ld_agu_be = 0;
    logic st_agu_valid = 0; logic [2:0] st_agu_idx = 0; logic [60:0] st_agu_dw = 0; logic [7:0] st_agu_be = 0;
    logic [63:0] st_agu_data = 0;
    logic ld_retire = 0, st_retire = 0;
    logic dc_req_valid, dc_req_write; logic [63:0] dc_req_addr, dc_req_wdata; logic [7:0] dc_req_be;
    logic dc_resp_valid = 0, dc_resp_nack = 0; logic [63:0] dc_resp_rdata = 0;
    logic ld_wb_valid, ld_wb_fwd; logic [2:0] ld_wb_idx; logic [63:0] ld_wb_data;
    logic flush_valid; logic [7:0] flush_seq;

    lsq_disambig u0 (.*);

    int n_tests = 0, n_fail = 0;
    logic [63:0] mem [logic [60:0]];
    logic [63:0] exp_data [8];
    bit exp_fwd [8], pending [8], got [8];
    int lq_tail_m = 0, sq_tail_m = 0, sq_cmt_m = 0;
    logic [60:0] st_dw_m [8]; logic [7:0] st_be_m [8]; logic [63:0] st_data_m [8];
    logic [60:0] wq_dw [$]; logic [7:0] wq_be [$]; logic [63:0] wq_data [$];
    bit outst = 0; int cd = 0; bit c_wr; logic [60:0] c_dw; logic [7:0] c_be; logic [63:0] c_wd;
    int nack_budget = 0, req_cnt = 0, flush_cnt = 0; logic [7:0] last_flush_seq = 0;

    task automatic chk(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    function automatic logic [63:0] bmask(input logic [7:0] be);
        logic [63:0] m = '0;
        for (int b = 0; b < 8; b++) if (be[b]) m[b*8 +: 8] = 8'hFF;
        return m;
    endfunction

    function automatic logic [63:0] memrd(input logic [60:0] a);
        if (mem.exists(a)) return mem[a];
        return {a[31:0] ^ 32'hA5A5_0000, ~a[31:0]};
    endfunction

    // Monitor and behavioural cache, every falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (ld_wb_valid) begin
                chk(pending[ld_wb_idx], "R3/R5 unexpected completion", 64'(ld_wb_idx), 64'(0));
                chk(ld_wb_data == exp_data[ld_wb_idx], "R3/R4/R5 load data", ld_wb_data, exp_data[ld_wb_idx]);
                chk(ld_wb_fwd == exp_fwd[ld_wb_idx], "R3/R5 forward flag", 64'(ld_wb_fwd), 64'(exp_fwd[ld_wb_idx]));
                got[ld_wb_idx] = 1; pending[ld_wb_idx] = 0;
            end
            if (flush_valid) begin
                flush_cnt++; last_flush_seq = flush_seq;
            end
            dc_resp_valid <= 1'b0; dc_resp_nack <= 1'b0;
            if (cd > 0) begin
                cd--;
                if (cd == 0) begin
                    dc_resp_valid <= 1'b1;
                    outst = 0;
                    if (nack_budget > 0) begin
                        nack_budget--; dc_resp_nack <= 1'b1;
                    end else if (c_wr) begin
                        chk(wq_dw.size() != 0, "R10 write without retire", 64'(c_dw), 64'(0));
                        if (wq_dw.size() != 0) begin
                            chk(c_dw == wq_dw[0] && c_be == wq_be[0] && c_wd == wq_data[0],
                                "R10 store write order", c_wd, wq_data[0]);
                            void'(wq_dw.pop_front()); void'(wq_be.pop_front()); void'(wq_data.pop_front());
                        end
                        mem[c_dw] = (memrd(c_dw) & ~bmask(c_be)) | (c_wd & bmask(c_be));
                    end else begin
                        dc_resp_rdata <= memrd(c_dw);
                    end
                end
            end
            if (dc_req_valid) begin
                chk(!outst, "R12 second request outstanding", 64'(1), 64'(0));
                outst = 1; cd = 2; req_cnt++;
                c_wr = dc_req_write; c_dw = dc_req_addr[63:3]; c_be = dc_req_be; c_wd = dc_req_wdata;
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic alloc_ld(input bit spec, input logic [7:0] seq, output int idx);
        chk(ld_alloc_idx == 3'(lq_tail_m), "R2 load slot index", 64'(ld_alloc_idx), 64'(lq_tail_m));
        idx = lq_tail_m; got[idx] = 0; pending[idx] = 0;
        ld_alloc_valid = 1; ld_alloc_spec = spec; ld_alloc_seq = seq;
        @(negedge clk); ld_alloc_valid = 0;
        lq_tail_m = (lq_tail_m + 1) % 8;
    endtask

    task automatic alloc_st(output int idx);
        chk(st_alloc_idx == 3'(sq_tail_m), "R2 store slot index", 64'(st_alloc_idx), 64'(sq_tail_m));
        idx = sq_tail_m;
        st_alloc_valid = 1; @(negedge clk); st_alloc_valid = 0;
        sq_tail_m = (sq_tail_m + 1) % 8;
    endtask

    task automatic agu_ld(input int idx, input logic [60:0] dw, input logic [7:0] be,
                          input logic [63:0] ed, input bit ef);
        exp_data[idx] = ed; exp_fwd[idx] = ef; pending[idx] = 1; got[idx] = 0;
        ld_agu_valid = 1; ld_agu_idx = 3'(idx); ld_agu_dw = dw; ld_agu_be = be;
        @(negedge clk); ld_agu_valid = 0;
    endtask

    task automatic agu_st(input int idx, input logic [60:0] dw, input logic [7:0] be, input logic [63:0] d);
        st_dw_m[idx] = dw; st_be_m[idx] = be; st_data_m[idx] = d;
        st_agu_valid = 1; st_agu_idx = 3'(idx); st_agu_dw = dw; st_agu_be = be; st_agu_data = d;
        @(negedge clk); st_agu_valid = 0;
    endtask

    task automatic ret_st();
        wq_dw.push_back(st_dw_m[sq_cmt_m]); wq_be.push_back(st_be_m[sq_cmt_m]);
        wq_data.push_back(st_data_m[sq_cmt_m]);
        sq_cmt_m = (sq_cmt_m + 1) % 8;
        st_retire = 1; @(negedge clk); st_retire = 0;
    endtask

    task automatic ret_ld();
        ld_retire = 1; @(negedge clk); ld_retire = 0;
    endtask

    task automatic wait_wb(input int idx, input string r);
        int t = 0;
        while (!got[idx] && t < 300) begin @(negedge clk); t++; end
        chk(got[idx], r, 64'(got[idx]), 64'(1));
    endtask

    task automatic wait_drain();
        int t = 0;
        while ((wq_dw.size() != 0 || outst || cd != 0) && t < 500) begin @(negedge clk); t++; end
        cyc(2);
        chk(wq_dw.size() == 0, "R10 stores drained", 64'(wq_dw.size()), 64'(0));
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int l0, l1, s0, s1, s2, r0, f0;
        logic [63:0] v;
        cyc(3); rst_n = 1; cyc(1);
        // R1: reset state
        chk(!lq_full && !sq_full, "R1 full flags", {lq_full, sq_full}, 0);
        chk(ld_alloc_idx == 0 && st_alloc_idx == 0, "R1 slot indexes", {ld_alloc_idx, st_alloc_idx}, 0);
        chk(!dc_req_valid && !ld_wb_valid && !flush_valid, "R1 idle outputs",
            {dc_req_valid, ld_wb_valid, flush_valid}, 0);

        // R5: no stores, read the cache
        alloc_ld(0, 8'h01, l0);
        agu_ld(l0, 61'h20, 8'hFF, memrd(61'h20), 0);
        wait_wb(l0, "R5 cache load completes");
        ret_ld();

        // R3 R4: youngest of two older stores forwards; younger store ignored
        alloc_st(s0); alloc_st(s1); alloc_ld(0, 8'h02, l0); alloc_st(s2);
        agu_st(s0, 61'h40, 8'hFF, 64'h1111_2222_3333_4444);
        agu_st(s1, 61'h40, 8'h0F, 64'h0000_0000_DEAD_BEEF);
        agu_st(s2, 61'h40, 8'hFF, 64'hCCCC_CCCC_CCCC_CCCC);
        r0 = req_cnt;
        agu_ld(l0, 61'h40, 8'h0F, 64'h0000_0000_DEAD_BEEF, 1);
        wait_wb(l0, "R4 forward completes");
        chk(req_cnt == r0, "R3 no cache read on forward", 64'(req_cnt), 64'(r0));
        cyc(10);
        chk(req_cnt == r0, "R10 no write before retire", 64'(req_cnt), 64'(r0));
        ret_ld(); ret_st(); ret_st(); ret_st();
        wait_drain();

        // R6 R8: non-speculative load waits, then late store forwards
        alloc_st(s0); alloc_ld(0, 8'h03, l0);
        r0 = req_cnt; f0 = flush_cnt;
        agu_ld(l0, 61'h60, 8'hFF, 64'h0123_4567_89AB_CDEF, 1);
        cyc(12);
        chk(req_cnt == r0 && !got[l0], "R6 load held", 64'(req_cnt - r0), 64'(0));
        agu_st(s0, 61'h60, 8'hFF, 64'h0123_4567_89AB_CDEF);
        wait_wb(l0, "R8 late forward");
        chk(flush_cnt == f0, "R7 no flush for held load", 64'(flush_cnt), 64'(f0));
        ret_st(); ret_ld();
        wait_drain();

        // R7: speculative load runs ahead, overlapping store flushes
        alloc_st(s0); alloc_ld(1, 8'h55, l0);
        f0 = flush_cnt;
        agu_ld(l0, 61'h80, 8'hFF, memrd(61'h80), 0);
        wait_wb(l0, "R7 speculative load issues");
        agu_st(s0, 61'h80, 8'h01, 64'h0000_0000_0000_0077);
        cyc(3);
        chk(flush_cnt == f0 + 1, "R7 flush raised", 64'(flush_cnt - f0), 64'(1));
        chk(last_flush_seq == 8'h55, "R7 flush sequence", 64'(last_flush_seq), 64'h55);
        alloc_st(s1); alloc_ld(1, 8'h66, l1);
        agu_ld(l1, 61'hA0, 8'hFF, memrd(61'hA0), 0);
        wait_wb(l1, "R7 second speculative load");
        agu_st(s1, 61'hA1, 8'hFF, 64'h5);
        cyc(3);
        chk(flush_cnt == f0 + 1, "R7 no flush on mismatch", 64'(flush_cnt - f0), 64'(1));
        ret_st(); ret_ld(); ret_st(); ret_ld();
        wait_drain();

        // R9: partial overlap waits for the store to drain
        alloc_st(s0); alloc_ld(0, 8'h07, l0);
        agu_st(s0, 61'hC0, 8'h0F, 64'h0000_0000_1234_5678);
        v = (memrd(61'hC0) & 64'hFFFF_FFFF_0000_0000) | 64'h1234_5678;
        agu_ld(l0, 61'hC0, 8'hFF, v, 0);
        cyc(12);
        chk(!got[l0], "R9 partial overlap holds", 64'(got[l0]), 64'(0));
        ret_st();
        wait_wb(l0, "R9 read after drain");
        ret_ld();
        wait_drain();

        // R11: nacked reads are retried
        nack_budget = 2;
        alloc_ld(0, 8'h08, l0);
        r0 = req_cnt;
        agu_ld(l0, 61'hE0, 8'hF0, memrd(61'hE0) & 64'hFFFF_FFFF_0000_0000, 0);
        wait_wb(l0, "R11 load after nacks");
        chk(req_cnt - r0 == 3, "R11 retry count", 64'(req_cnt - r0), 64'(3));
        ret_ld();

        // R2: fill load queue
        for (int k = 0; k < 8; k++) alloc_ld(0, 8'(k), l0);
        chk(lq_full, "R2 load queue full", 64'(lq_full), 64'(1));
        for (int k = 0; k < 8; k++) ret_ld();
        chk(!lq_full, "R2 load queue drained", 64'(lq_full), 64'(0));

        // R2 R10: fill store queue, retire all, writes in order
        for (int k = 0; k < 8; k++) alloc_st(s0);
        chk(sq_full, "R2 store queue full", 64'(sq_full), 64'(1));
        for (int k = 0; k < 8; k++) agu_st((sq_tail_m + k) % 8, 61'h100 + 61'(k), 8'hFF, 64'(k * 3 + 1));
        for (int k = 0; k < 8; k++) ret_st();
        wait_drain();
        chk(!sq_full, "R2 store queue empty", 64'(sq_full), 64'(0));

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule